// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block watches the SCL and SDA lines of an I2C bus and, when asked, returns a hung bus to the idle state. Both lines pass through a synchroniser. The block then reports their levels and keeps a bus-busy flag from the START and STOP conditions it sees. Host logic reads these through a status word and starts a recovery by writing a command word with the recover bit set.

At the moment of the command the block looks at the lines and picks one of three paths:
- **Both lines high:** nothing is driven and the block reports completion at once.
- **SCL low, SDA high:** the block issues a STOP condition only.
- **SDA held low by a target:** the block clocks SCL, up to a bounded number of pulses, until the target lets SDA go. It then issues a STOP.

Every phase of the SCL and STOP waveforms lasts one interval of an external tick, which comes from the SCL timing generator. Completion sets a sticky recover-done bit in an interrupt word. That bit drives the interrupt line until it is written off.

The drive outputs are open-drain requests: a 1 means pull the line low, and a 0 means release it.

Top module: `i2c_bus_recovery`

## Requirements
- R1: `status_word` bit 18 shows the synchronised SCL level and bit 17 the synchronised SDA level, each two clocks after the pin. Bit 16 shows bus busy. All other bits read 0. After reset the word is 0x0006_0000.
- R2: Bus busy is set one clock after the synchronised lines show SDA falling while SCL stays high (START). It is cleared one clock after they show SDA rising while SCL stays high (STOP). It is 0 after reset.
- R3: A recovery starts only on a clock where `cmd_valid` is 1 and `cmd_data` bit 11 is 1. A command with bit 11 clear has no effect. A command that arrives while a recovery is in progress has no effect on its pulse count.
- R4: If both synchronised lines are high when the command is taken, neither line is driven and recover-done is raised two clocks later.
- R5: If SCL is low and SDA is high when the command is taken, the block drives exactly one SCL low phase as part of a single STOP condition and issues no clock pulses.
- R6: If SDA is low when the command is taken, the block issues SCL pulses, each one tick interval low and one tick interval high. It stops after the first high phase that ends with SDA seen high, and never issues more than `MAX_PULSES` (default 8).
- R7: Once SDA has been released, the block generates a STOP before completion: SDA is pulled low while SCL is low, SCL is released, and then SDA is released while SCL is high. Recover-done follows only after that.
- R8: If SDA is still low at the end of the last allowed pulse, no STOP is attempted and recover-done is still raised. Status bit 17 then reads 0, which marks a failed recovery.
- R9: Completion sets `int_status` bit 13 and `irq`. Both stay set until a clock with `int_clr_valid` 1 and `int_clr_data` bit 13 set. A clear write with bit 13 at 0 leaves them set.
- R10: SDA is never pulled low during the pulse train. Every SDA pull begins while SCL is already being pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | SCL pin level (asynchronous) |
| sda_in | input | 1 | SDA pin level (asynchronous) |
| tick | input | 1 | One-clock phase tick from the SCL timing generator |
| cmd_valid | input | 1 | Command write strobe |
| cmd_data | input | WORD_W | Command word; bit 11 requests a recovery |
| int_clr_valid | input | 1 | Interrupt clear write strobe |
| int_clr_data | input | WORD_W | Write-one-to-clear mask; bit 13 clears recover-done |
| scl_drive_low | output | 1 | Request to pull SCL low |
| sda_drive_low | output | 1 | Request to pull SDA low |
| status_word | output | WORD_W | Line levels (bits 18, 17) and bus busy (bit 16) |
| int_status | output | WORD_W | Interrupt word; bit 13 is recover-done |
| irq | output | 1 | Interrupt request, high while recover-done is set |

## Verification
The assertions assume that ticks are spaced more than three clocks apart. This ensures the synchronised SDA level reflects a release made during a low phase before the following high phase ends. The bench drives ticks every eight clocks.

The assertions also assume that a target holding SCL low lets go during the STOP sequence. The bench's target model releases its SCL hold three clocks after the command and releases SDA on a chosen SCL falling edge.

All line changes from the bench are applied on the falling clock edge. The synchroniser therefore sees one clean level per clock, and the per-clock model of status and busy stays exact.

// File: rtl/i2c_rcv_pkg.sv
// Shared constants and state type for the I2C bus recovery sequencer.
// Bit positions are fixed because host software decodes them.
package i2c_rcv_pkg;
    localparam int STAT_SCL_BIT    = 18;
    localparam int STAT_SDA_BIT    = 17;
    localparam int STAT_BUSY_BIT   = 16;
    localparam int CMD_RECOVER_BIT = 11;
    localparam int INT_DONE_BIT    = 13;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_ALIGN,
        RS_PULSE_LO,
        RS_PULSE_HI,
        RS_STOP_LO,
        RS_STOP_HI,
        RS_FINISH
    } rcv_state_t;
endpackage

// File: rtl/i2c_rcv_sync.sv
// Multi-flop synchroniser for one bus line.
// Assumes the line idles high, so every stage resets to 1.
module i2c_rcv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    // Shift the pin level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], raw_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/i2c_rcv_linemon.sv
// Watches the synchronised lines for START and STOP conditions and keeps
// the bus-busy flag. Assumes inputs are already synchronous to clk.
module i2c_rcv_linemon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic busy
);
    logic scl_q, sda_q;
    logic start_det, stop_det;

    // Keep last cycle's line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign start_det = scl_q & scl_s &  sda_q & ~sda_s;
    assign stop_det  = scl_q & scl_s & ~sda_q &  sda_s;

    // Busy follows START (set) and STOP (clear).
    always_ff @(posedge clk) begin
        if (!rst_n)         busy <= 1'b0;
        else if (start_det) busy <= 1'b1;
        else if (stop_det)  busy <= 1'b0;
    end

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> busy) else $error("start did not set busy"); // R2
    AST_STOP_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !busy) else $error("stop did not clear busy"); // R2
endmodule

// File: rtl/i2c_rcv_fsm.sv
// Recovery sequencer. Chooses a path from the line levels seen when the
// command arrives, then steps one phase per tick. Assumes ticks are spaced
// more than the synchroniser latency apart.
module i2c_rcv_fsm
    import i2c_rcv_pkg::*;
#(
    parameter int MAX_PULSES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic tick,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_drv,
    output logic sda_drv,
    output logic done,
    output logic active
);
    localparam int CNT_W = $clog2(MAX_PULSES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_PULSES);

    rcv_state_t state, state_nx, state_prev;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic to_stop, to_stop_nx;
    logic fresh;

    assign fresh = (state != state_prev);

    // Next-state and pulse-count decisions.
    always_comb begin
        state_nx   = state;
        cnt_nx     = cnt;
        to_stop_nx = to_stop;
        case (state)
            RS_IDLE: begin
                if (go) begin
                    if (sda_s && scl_s) begin
                        state_nx = RS_FINISH;
                    end else begin
                        state_nx   = RS_ALIGN;
                        to_stop_nx = sda_s;
                    end
                end
            end
            RS_ALIGN: begin
                if (tick) begin
                    if (to_stop) begin
                        state_nx = RS_STOP_LO;
                    end else begin
                        state_nx = RS_PULSE_LO;
                        cnt_nx   = CNT_W'(1);
                    end
                end
            end
            RS_PULSE_LO: begin
                if (tick) state_nx = RS_PULSE_HI;
            end
            RS_PULSE_HI: begin
                if (tick) begin
                    if (sda_s) begin
                        state_nx = RS_STOP_LO;
                    end else if (cnt == CNT_MAX) begin
                        state_nx = RS_FINISH;
                    end else begin
                        state_nx = RS_PULSE_LO;
                        cnt_nx   = cnt + 1'b1;
                    end
                end
            end
            RS_STOP_LO: begin
                if (tick && !fresh) state_nx = RS_STOP_HI;
            end
            RS_STOP_HI: begin
                if (tick) state_nx = RS_FINISH;
            end
            RS_FINISH: begin
                state_nx = RS_IDLE;
                cnt_nx   = '0;
            end
            default: state_nx = RS_IDLE;
        endcase
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= RS_IDLE;
            state_prev <= RS_IDLE;
            cnt        <= '0;
            to_stop    <= 1'b0;
        end else begin
            state      <= state_nx;
            state_prev <= state;
            cnt        <= cnt_nx;
            to_stop    <= to_stop_nx;
        end
    end

    // SDA is pulled one clock after SCL in the STOP low phase so that the
    // monitor never sees a false START.
    assign scl_drv = (state == RS_PULSE_LO) || (state == RS_STOP_LO);
    assign sda_drv = ((state == RS_STOP_LO) && !fresh) || (state == RS_STOP_HI);
    assign done    = (state == RS_FINISH);
    assign active  = (state != RS_IDLE);

    AST_IDLE_BUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RS_IDLE && go && sda_s && scl_s) |=> (done && !scl_drv && !sda_drv))
        else $error("idle bus not finished at once"); // R4
    AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_drv) |-> (cnt <= CNT_MAX)) else $error("pulse count overflow"); // R6
    AST_SDA_REL_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_drv) |-> !scl_drv) else $error("SDA released with SCL low"); // R7
    AST_FAIL_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RS_PULSE_HI && tick && !sda_s && cnt == CNT_MAX) |=> (done && !sda_drv))
        else $error("no finish after last pulse"); // R8
    AST_SDA_ONLY_IN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drv) |-> scl_drv) else $error("SDA pulled outside STOP"); // R10
endmodule

// File: rtl/i2c_bus_recovery.sv
// Top of the I2C bus recovery sequencer: synchronises both lines, tracks
// bus busy, runs the recovery sequencer and holds the recover-done bit.
// Assumes WORD_W is wide enough to hold bit 18.
module i2c_bus_recovery
    import i2c_rcv_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MAX_PULSES  = 8,
    parameter int WORD_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              tick,
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] cmd_data,
    input  logic              int_clr_valid,
    input  logic [WORD_W-1:0] int_clr_data,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    output logic [WORD_W-1:0] status_word,
    output logic [WORD_W-1:0] int_status,
    output logic              irq
);
    localparam int NUM_LINES = 2;
    localparam int IDX_SDA   = 0;
    localparam int IDX_SCL   = 1;

    logic [NUM_LINES-1:0] raw_lines, sync_lines;
    logic busy, go, done, active, done_q;
    logic cmd_unused_bits, clr_unused_bits;

    assign raw_lines = {scl_in, sda_in};

    // One synchroniser per bus line.
    for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_sync
        i2c_rcv_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_in   (raw_lines[gi]),
            .sync_out (sync_lines[gi])
        );
    end

    i2c_rcv_linemon u_mon (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_s (sync_lines[IDX_SCL]),
        .sda_s (sync_lines[IDX_SDA]),
        .busy  (busy)
    );

    assign go = cmd_valid && cmd_data[CMD_RECOVER_BIT] && !active;

    i2c_rcv_fsm #(.MAX_PULSES(MAX_PULSES)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .tick    (tick),
        .scl_s   (sync_lines[IDX_SCL]),
        .sda_s   (sync_lines[IDX_SDA]),
        .scl_drv (scl_drive_low),
        .sda_drv (sda_drive_low),
        .done    (done),
        .active  (active)
    );

    // Sticky recover-done bit; a new completion wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_q <= 1'b0;
        else if (done)
            done_q <= 1'b1;
        else if (int_clr_valid && int_clr_data[INT_DONE_BIT])
            done_q <= 1'b0;
    end

    // Assemble the status and interrupt words.
    always_comb begin
        status_word                = '0;
        status_word[STAT_SCL_BIT]  = sync_lines[IDX_SCL];
        status_word[STAT_SDA_BIT]  = sync_lines[IDX_SDA];
        status_word[STAT_BUSY_BIT] = busy;
        int_status                 = '0;
        int_status[INT_DONE_BIT]   = done_q;
    end

    assign irq = done_q;

    assign cmd_unused_bits = ^cmd_data;
    assign clr_unused_bits = ^int_clr_data;

    AST_DONE_SETS_INT: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> int_status[INT_DONE_BIT]) else $error("done not latched"); // R9
    AST_INT_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(done)) else $error("spurious recover-done"); // R9
    AST_CMD_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !(cmd_valid && cmd_data[CMD_RECOVER_BIT])) |=> !scl_drive_low && !sda_drive_low)
        else $error("drive without command"); // R3
endmodule

// File: tb/i2c_bus_recovery_tb_top.sv
`timescale 1ns/1ps
module i2c_bus_recovery_tb_top;
    localparam int TICK_PER = 8;
    localparam int MAXP     = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic cmd_valid = 1'b0;
    logic [31:0] cmd_data = '0;
    logic int_clr_valid = 1'b0;
    logic [31:0] int_clr_data = '0;
    logic scl_drive_low, sda_drive_low, irq;
    logic [31:0] status_word, int_status;

    // target model state (written only by the monitor block)
    logic tgt_scl_hold = 1'b0;
    logic tgt_sda_hold = 1'b0;
    // requests from the stimulus tasks
    logic req_scl_hold = 1'b0;
    logic req_sda_hold = 1'b0;
    int   release_at = 0;

    logic scl_line, sda_line;
    assign scl_line = !(scl_drive_low || tgt_scl_hold);
    assign sda_line = !(sda_drive_low || tgt_sda_hold);

    int tests = 0, fails = 0, mon_tests = 0, mon_fails = 0;
    int scl_rises = 0, sda_rises = 0, stops_seen = 0;

    always #2.5 clk = ~clk;

    i2c_bus_recovery dut_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
        .tick(tick), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .int_clr_valid(int_clr_valid), .int_clr_data(int_clr_data),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .status_word(status_word), .int_status(int_status), .irq(irq)
    );

    // Behavioural model: line history, busy, target and event counters.
    logic h_scl [0:3];
    logic h_sda [0:3];
    logic busy_m = 1'b0;
    logic p_scl = 1'b1, p_sda = 1'b1, p_sdrv = 1'b0, p_ddrv = 1'b0;
    int   tick_cnt = 0, n_falls = 0, low_run = 0;
    logic released = 1'b0;
    initial for (int i = 0; i < 4; i++) begin h_scl[i] = 1'b1; h_sda[i] = 1'b1; end

    always @(negedge clk) begin
        logic c_scl, c_sda, st, sp;
        logic [31:0] exp_w;
        tgt_scl_hold = req_scl_hold;
        c_scl = !(scl_drive_low || tgt_scl_hold);
        if (!req_sda_hold) begin
            n_falls = 0;
            released = 1'b0;
        end else if (p_scl && !c_scl) begin
            n_falls++;
            if (release_at != 0 && n_falls == release_at) released = 1'b1;
        end
        tgt_sda_hold = req_sda_hold && !released;
        c_sda = !(sda_drive_low || tgt_sda_hold);
        tick_cnt = (tick_cnt == TICK_PER - 1) ? 0 : tick_cnt + 1;
        tick = (tick_cnt == 0);
        if (rst_n) begin
            st = h_scl[3] && h_scl[2] && h_sda[3] && !h_sda[2];
            sp = h_scl[3] && h_scl[2] && !h_sda[3] && h_sda[2];
            if (st) busy_m = 1'b1;
            else if (sp) busy_m = 1'b0;
            exp_w = '0;
            exp_w[18] = h_scl[1];
            exp_w[17] = h_sda[1];
            exp_w[16] = busy_m;
            mon_tests++;
            if (status_word !== exp_w) begin
                mon_fails++;
                $display("FAIL R1/R2 status_word act=%h exp=%h", status_word, exp_w);
            end
            if (scl_drive_low && !p_sdrv) scl_rises++;
            if (sda_drive_low && !p_ddrv) begin
                sda_rises++;
                mon_tests++;
                if (!scl_drive_low) begin
                    mon_fails++;
                    $display("FAIL R10 SDA pulled with SCL released act=0 exp=1");
                end
            end
            if (scl_drive_low) low_run++;
            else if (p_sdrv) begin
                mon_tests++;
                if (low_run != TICK_PER) begin
                    mon_fails++;
                    $display("FAIL R6 SCL low phase act=%0d exp=%0d", low_run, TICK_PER);
                end
                low_run = 0;
            end
            if (c_sda && !p_sda && c_scl && p_scl) stops_seen++;
        end
        for (int i = 3; i > 0; i--) begin h_scl[i] = h_scl[i-1]; h_sda[i] = h_sda[i-1]; end
        h_scl[0] = c_scl;
        h_sda[0] = c_sda;
        p_scl = c_scl; p_sda = c_sda;
        p_sdrv = scl_drive_low; p_ddrv = sda_drive_low;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic do_cmd(input logic [31:0] d);
        @(negedge clk); #1;
        cmd_valid = 1'b1; cmd_data = d;
        @(negedge clk); #1;
        cmd_valid = 1'b0; cmd_data = '0;
    endtask

    task automatic do_clr(input logic [31:0] d);
        @(negedge clk); #1;
        int_clr_valid = 1'b1; int_clr_data = d;
        @(negedge clk); #1;
        int_clr_valid = 1'b0; int_clr_data = '0;
    endtask

    task automatic recover(input string req, input bit hold_sda, input int k, input bit hold_scl,
                           input bit mid_cmd, input int exp_p, input int exp_d, input int exp_s,
                           input bit exp_sda, input bit exp_busy);
        int s0, d0, t0, w;
        req_sda_hold = hold_sda; release_at = k; req_scl_hold = hold_scl;
        cyc(6);
        if (hold_sda) chk("R2", "busy after START", {31'd0, status_word[16]}, 32'd1);
        s0 = scl_rises; d0 = sda_rises; t0 = stops_seen;
        do_cmd(32'h0000_0800);
        if (hold_scl) begin cyc(3); req_scl_hold = 1'b0; end
        if (mid_cmd) begin
            while (scl_rises - s0 < 2) @(negedge clk);
            do_cmd(32'h0000_0800);
        end
        w = 0;
        while (!int_status[13] && w < 600) begin @(negedge clk); w++; end
        chk(req, "recover-done", {31'd0, int_status[13]}, 32'd1);
        chk("R9", "irq", {31'd0, irq}, 32'd1);
        chk(req, "SCL pulses", scl_rises - s0, exp_p);
        chk(req, "SDA pulls", sda_rises - d0, exp_d);
        chk("R7", "STOPs", stops_seen - t0, exp_s);
        cyc(6);
        chk(req, "SDA level after", {31'd0, status_word[17]}, {31'd0, exp_sda});
        chk("R2", "busy after", {31'd0, status_word[16]}, {31'd0, exp_busy});
        do_clr(32'h0000_2000);
        chk("R9", "cleared", int_status, 32'd0);
        req_sda_hold = 1'b0; req_scl_hold = 1'b0;
        cyc(6);
    endtask

    initial begin
        int s0;
        cyc(5);
        rst_n = 1'b1;
        cyc(3);
        chk("R1", "reset status", status_word, 32'h0006_0000);
        chk("R9", "reset int", int_status, 32'd0);
        chk("R1", "reset drives", {30'd0, scl_drive_low, sda_drive_low}, 32'd0);
        // R2: START and STOP made by the target
        req_sda_hold = 1'b1; cyc(6);
        chk("R2", "busy set", {31'd0, status_word[16]}, 32'd1);
        req_sda_hold = 1'b0; cyc(6);
        chk("R2", "busy clear", {31'd0, status_word[16]}, 32'd0);
        // R3: command without the recover bit
        s0 = scl_rises;
        do_cmd(32'hFFFF_F7FF);
        cyc(4 * TICK_PER);
        chk("R3", "no pulses", scl_rises - s0, 32'd0);
        chk("R3", "no int", int_status, 32'd0);
        // R4 and R9: idle bus, clear with wrong bit first
        s0 = scl_rises;
        do_cmd(32'h0000_0800);
        cyc(2);
        chk("R4", "done on idle", {31'd0, int_status[13]}, 32'd1);
        chk("R4", "no drive", scl_rises - s0, 32'd0);
        do_clr(32'h0000_0001);
        chk("R9", "wrong clear bit", {31'd0, int_status[13]}, 32'd1);
        do_clr(32'h0000_2000);
        chk("R9", "clear", {31'd0, irq}, 32'd0);
        // R5: SCL stuck low, SDA high
        recover("R5", 1'b0, 0, 1'b1, 1'b0, 1, 1, 1, 1'b1, 1'b0);
        // R6/R7: SDA stuck, released after k pulses
        recover("R6", 1'b1, 1, 1'b0, 1'b0, 2, 1, 1, 1'b1, 1'b0);
        recover("R6", 1'b1, 3, 1'b0, 1'b0, 4, 1, 1, 1'b1, 1'b0);
        recover("R7", 1'b1, MAXP, 1'b0, 1'b0, MAXP + 1, 1, 1, 1'b1, 1'b0);
        // R8: never released within the limit
        recover("R8", 1'b1, 12, 1'b0, 1'b0, MAXP, 0, 0, 1'b0, 1'b1);
        chk("R2", "busy after late release", {31'd0, status_word[16]}, 32'd0);
        // R3: second command during a train is ignored
        recover("R3", 1'b1, 5, 1'b0, 1'b1, 6, 1, 1, 1'b1, 1'b0);
        $display("[TB] %0d tests run, %0d failed", tests + mon_tests, fails + mon_fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        $display("FAIL watchdog expired act=running exp=finished");
        $display("[TB] %0d tests run, %0d failed", tests + mon_tests + 1, fails + mon_fails + 1);
        $finish;
    end
endmodule